// File: doc/BRIEF.md
# Four-Port Shared Arithmetic and Shift Service

This block lets four independent requesters share one adder/subtractor and one barrel shifter. Each requester has its own command lines, data lines, result lines and response lines. A request is a two-beat transfer:

- The first beat carries the command code and the first operand.
- The next beat carries the second operand.

The block then holds the request in a per-port slot until the execution resource it needs is free. It computes the answer and returns a one-cycle response, with the result data, on the same port that issued the request.

The two execution resources work independently, so an arithmetic request and a shift request can complete in the same cycle. Requests that contend for the same resource are served oldest first. Requests that became ready in the same cycle are ordered by the lower port number. Each port holds one request at a time. A command presented while the port's request is still waiting is refused with an error response, and the waiting request is kept.

Top module: `calc_hub`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, every port shows response 0 and result 0.
- R2: Command code 1 (add) with no other request pending produces response 1 with the 32-bit sum. The response is visible for exactly one cycle, three cycles after the cycle in which the command was presented.
- R3: Command code 2 returns first operand minus second operand with response 1. When the second operand is larger (a borrow), it returns response 2 with result 0.
- R4: An add whose unsigned sum exceeds 32 bits returns response 2 with result 0. A sum of exactly 0xFFFFFFFF is a normal success.
- R5: Code 5 shifts the first operand left and code 6 shifts it right. The shift amount is bits [4:0] of the second operand, vacated bits are zero, and the response is 1.
- R6: Any command code other than 0, 1, 2, 5 and 6 returns response 2 with result 0. That response is visible two cycles after the command cycle, one cycle after the second-operand cycle.
- R7: Command code 0 on an idle port produces no response, whatever is on its data lines.
- R8: The command lines of a port are not sampled in its second-operand cycle. A nonzero code there changes neither the result nor the response count.
- R9: A nonzero command on a port whose request is still waiting returns response 2 with result 0 in the next cycle. The refused command is discarded. The waiting request is not served in that cycle and completes later with its own result.
- R10: At most one arithmetic request and at most one shift request are granted per cycle.
- R11: Among requests waiting for the same resource, the one that became ready earliest is served first. Requests that became ready in the same cycle are served in ascending port order.
- R12: An arithmetic request and a shift request that become ready together both complete in the same cycle.
- R13: Response 0 always comes with result 0, and response 2 always comes with result 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| cmd_i | input | 4x4 | Per-port command code, port p at [p] |
| data_i | input | 4x32 | Per-port data: first operand with the command, second operand in the next cycle |
| resp_o | output | 4x2 | Per-port response: 0 none, 1 success, 2 error |
| data_o | output | 4x32 | Per-port result, valid in the cycle of its response |

## Verification
Single requests on an otherwise quiet block pin down the three-cycle latency and the result of each operation. Carry, borrow and shift-amount boundary operands separate a correct 33-bit check and 5-bit amount from truncated or unmasked versions. Staggered and simultaneous arrivals of arithmetic requests on ports 1, 3 and 0 tell age order apart from plain port priority and from a round-robin pointer. A paired add and shift shows that the two resources do not block each other. A command presented in the operand-2 cycle, and another presented while the request waits, separate the ignored case from the refused case, and show that the refused command neither runs nor displaces the waiting request.

// File: rtl/calc_pkg.sv
package calc_pkg;

    localparam int CMD_W   = 4;
    localparam int DATA_W  = 32;
    localparam int RESP_W  = 2;
    localparam int SHAMT_W = $clog2(DATA_W);
    localparam int NUNIT   = 2;
    localparam int U_ARITH = 0;
    localparam int U_SHIFT = 1;

    localparam logic [CMD_W-1:0] OP_NOP = 4'd0;
    localparam logic [CMD_W-1:0] OP_ADD = 4'd1;
    localparam logic [CMD_W-1:0] OP_SUB = 4'd2;
    localparam logic [CMD_W-1:0] OP_SHL = 4'd5;
    localparam logic [CMD_W-1:0] OP_SHR = 4'd6;

    typedef enum logic [RESP_W-1:0] {
        RSP_NONE = 2'd0,
        RSP_OK   = 2'd1,
        RSP_ERR  = 2'd2,
        RSP_INT  = 2'd3
    } rsp_e;

    typedef enum logic [1:0] {
        PS_IDLE = 2'd0,
        PS_OP2  = 2'd1,
        PS_WAIT = 2'd2
    } pst_e;

    typedef struct packed {
        logic [CMD_W-1:0]  code;
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] b;
    } job_t;

    typedef struct packed {
        rsp_e              resp;
        logic [DATA_W-1:0] data;
    } res_t;

    function automatic logic code_legal(input logic [CMD_W-1:0] c);
        return (c == OP_ADD) || (c == OP_SUB) || (c == OP_SHL) || (c == OP_SHR);
    endfunction

    function automatic logic needs_shifter(input logic [CMD_W-1:0] c);
        return (c == OP_SHL) || (c == OP_SHR);
    endfunction

    // Unsigned add/subtract with a 33-bit check for carry-out or borrow.
    function automatic res_t arith_eval(input job_t j);
        logic [DATA_W:0] wide;
        res_t r;
        if (j.code == OP_SUB)
            wide = {1'b0, j.a} - {1'b0, j.b};
        else
            wide = {1'b0, j.a} + {1'b0, j.b};
        if (wide[DATA_W]) begin
            r.resp = RSP_ERR;
            r.data = '0;
        end else begin
            r.resp = RSP_OK;
            r.data = wide[DATA_W-1:0];
        end
        return r;
    endfunction

    // Logical shift, amount taken from the low bits of the second operand.
    function automatic res_t shift_eval(input job_t j);
        logic [SHAMT_W-1:0] amt;
        res_t r;
        amt    = j.b[SHAMT_W-1:0];
        r.resp = RSP_OK;
        if (j.code == OP_SHL)
            r.data = j.a << amt;
        else
            r.data = j.a >> amt;
        return r;
    endfunction

endpackage

// File: rtl/calc_port_ctl.sv
module calc_port_ctl
    import calc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CMD_W-1:0]  cmd_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              add_gnt_i,
    input  logic              shf_gnt_i,
    input  res_t              add_res_i,
    input  res_t              shf_res_i,
    output pst_e              st_o,
    output job_t              job_o,
    output logic              enter_o,
    output logic              want_add_o,
    output logic              want_shf_o,
    output logic [RESP_W-1:0] resp_o,
    output logic [DATA_W-1:0] data_o
);

    pst_e st_q, st_n;
    job_t job_q, job_n;
    res_t out_q, out_n;

    always_comb begin
        st_n       = st_q;
        job_n      = job_q;
        out_n.resp = RSP_NONE;
        out_n.data = '0;
        unique case (st_q)
            PS_IDLE: begin
                if (cmd_i != OP_NOP) begin
                    job_n.code = cmd_i;
                    job_n.a    = data_i;
                    job_n.b    = '0;
                    st_n       = PS_OP2;
                end
            end
            PS_OP2: begin
                // Command lines are not looked at in this cycle.
                job_n.b = data_i;
                if (code_legal(job_q.code)) begin
                    st_n = PS_WAIT;
                end else begin
                    st_n       = PS_IDLE;
                    out_n.resp = RSP_ERR;
                end
            end
            PS_WAIT: begin
                if (cmd_i != OP_NOP) begin
                    out_n.resp = RSP_ERR;
                end else if (add_gnt_i) begin
                    out_n = add_res_i;
                    st_n  = PS_IDLE;
                end else if (shf_gnt_i) begin
                    out_n = shf_res_i;
                    st_n  = PS_IDLE;
                end
            end
            default: st_n = PS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= PS_IDLE;
            job_q <= '0;
            out_q <= '0;
        end else begin
            st_q  <= st_n;
            job_q <= job_n;
            out_q <= out_n;
        end
    end

    logic waiting_free;
    assign waiting_free = (st_q == PS_WAIT) && (cmd_i == OP_NOP);

    assign st_o       = st_q;
    assign job_o      = job_q;
    assign enter_o    = (st_q == PS_OP2) && code_legal(job_q.code);
    assign want_add_o = waiting_free && !needs_shifter(job_q.code);
    assign want_shf_o = waiting_free && needs_shifter(job_q.code);
    assign resp_o     = out_q.resp;
    assign data_o     = out_q.data;

endmodule

// File: rtl/calc_age_track.sv
module calc_age_track #(
    parameter int N = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N-1:0]        enter_i,
    output logic [N-1:0][N-1:0] older_o
);

    // older_q[i][j] set: slot i became ready before slot j.
    logic [N-1:0][N-1:0] older_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            older_q <= '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                for (int j = 0; j < N; j++) begin
                    if (i == j)
                        older_q[i][j] <= 1'b0;
                    else if (enter_i[i])
                        older_q[i][j] <= enter_i[j] && (i < j);
                    else if (enter_i[j])
                        older_q[i][j] <= 1'b1;
                end
            end
        end
    end

    assign older_o = older_q;

endmodule

// File: rtl/calc_age_arb.sv
module calc_age_arb #(
    parameter int N = 4
) (
    input  logic [N-1:0]        req_i,
    input  logic [N-1:0][N-1:0] older_i,
    output logic [N-1:0]        gnt_o
);

    logic [N-1:0] blocked;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            blocked[i] = 1'b0;
            for (int j = 0; j < N; j++) begin
                if ((j != i) && req_i[j] && older_i[j][i])
                    blocked[i] = 1'b1;
            end
            gnt_o[i] = req_i[i] && !blocked[i];
        end
    end

endmodule

// File: rtl/calc_hub.sv
module calc_hub
    import calc_pkg::*;
#(
    parameter int NPORT = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NPORT-1:0][CMD_W-1:0]   cmd_i,
    input  logic [NPORT-1:0][DATA_W-1:0]  data_i,
    output logic [NPORT-1:0][RESP_W-1:0]  resp_o,
    output logic [NPORT-1:0][DATA_W-1:0]  data_o
);

    pst_e [NPORT-1:0]            pst_vec;
    job_t [NPORT-1:0]            jobs;
    logic [NPORT-1:0]            enter_vec;
    logic [NPORT-1:0][NPORT-1:0] older;
    logic [NUNIT-1:0][NPORT-1:0] want;
    logic [NUNIT-1:0][NPORT-1:0] gnt;
    logic [NPORT-1:0]            add_gnt, shf_gnt;
    job_t                        add_job, shf_job;
    res_t                        add_res, shf_res;

    assign add_gnt = gnt[U_ARITH];
    assign shf_gnt = gnt[U_SHIFT];

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        calc_port_ctl port_i (
            .clk       (clk),
            .rst       (rst),
            .cmd_i     (cmd_i[p]),
            .data_i    (data_i[p]),
            .add_gnt_i (add_gnt[p]),
            .shf_gnt_i (shf_gnt[p]),
            .add_res_i (add_res),
            .shf_res_i (shf_res),
            .st_o      (pst_vec[p]),
            .job_o     (jobs[p]),
            .enter_o   (enter_vec[p]),
            .want_add_o(want[U_ARITH][p]),
            .want_shf_o(want[U_SHIFT][p]),
            .resp_o    (resp_o[p]),
            .data_o    (data_o[p])
        );
    end

    calc_age_track #(.N(NPORT)) age_i (
        .clk    (clk),
        .rst    (rst),
        .enter_i(enter_vec),
        .older_o(older)
    );

    for (genvar u = 0; u < NUNIT; u++) begin : g_unit
        calc_age_arb #(.N(NPORT)) arb_i (
            .req_i  (want[u]),
            .older_i(older),
            .gnt_o  (gnt[u])
        );
    end

    // Grants are one-hot per unit, so a plain select suffices.
    always_comb begin
        add_job = '0;
        shf_job = '0;
        for (int p = 0; p < NPORT; p++) begin
            if (add_gnt[p]) add_job = jobs[p];
            if (shf_gnt[p]) shf_job = jobs[p];
        end
    end

    assign add_res = arith_eval(add_job);
    assign shf_res = shift_eval(shf_job);

endmodule

// File: rtl/calc_hub_chk.sv
module calc_hub_chk
    import calc_pkg::*;
#(
    parameter int NPORT = 4
) (
    input logic                         clk,
    input logic                         rst,
    input logic [NPORT-1:0][CMD_W-1:0]  cmd_i,
    input logic [NPORT-1:0][RESP_W-1:0] resp_o,
    input logic [NPORT-1:0][DATA_W-1:0] data_o,
    input logic [NPORT-1:0]             add_gnt,
    input logic [NPORT-1:0]             shf_gnt,
    input pst_e [NPORT-1:0]             pst_vec
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) rst |=> (resp_o == '0 && data_o == '0));

    // R10
    one_add_grant_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(add_gnt));

    // R10
    one_shf_grant_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(shf_gnt));

    for (genvar p = 0; p < NPORT; p++) begin : g_p
        // R7
        idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
            (pst_vec[p] == PS_IDLE) |=> (resp_o[p] == RSP_NONE));

        // R9
        busy_reject_chk: assert property (@(posedge clk) disable iff (rst)
            (pst_vec[p] == PS_WAIT && cmd_i[p] != OP_NOP) |=> (resp_o[p] == RSP_ERR && data_o[p] == '0));

        // R6
        bad_code_chk: assert property (@(posedge clk) disable iff (rst)
            (pst_vec[p] == PS_OP2 && !code_legal($past(cmd_i[p]))) |=> (resp_o[p] == RSP_ERR));

        // R13
        zero_data_chk: assert property (@(posedge clk) disable iff (rst)
            (resp_o[p] != RSP_OK) |-> (data_o[p] == '0));
    end

endmodule

bind calc_hub calc_hub_chk #(.NPORT(NPORT)) chk_i (
    .clk    (clk),
    .rst    (rst),
    .cmd_i  (cmd_i),
    .resp_o (resp_o),
    .data_o (data_o),
    .add_gnt(add_gnt),
    .shf_gnt(shf_gnt),
    .pst_vec(pst_vec)
);

// File: tb/calc_hub_tb_top.sv
`timescale 1ns/1ps
module calc_hub_tb_top;

    localparam int NP = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NP-1:0][3:0]  cmd = '0;
    logic [NP-1:0][31:0] din = '0;
    logic [NP-1:0][1:0]  resp;
    logic [NP-1:0][31:0] dout;

    calc_hub #(.NPORT(NP)) dut_i (
        .clk   (clk),
        .rst   (rst),
        .cmd_i (cmd),
        .data_i(din),
        .resp_o(resp),
        .data_o(dout)
    );

    always #4 clk = ~clk;

    typedef struct {
        int          cyc;
        logic [1:0]  r;
        logic [31:0] d;
        string       tag;
    } exp_t;

    exp_t sbq [NP][$];
    int   cyc = 0;
    int   nchk = 0;
    int   nbad = 0;
    bit   done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: pops and compares each response as it appears.
    always @(negedge clk) begin
        if (!rst) begin
            for (int p = 0; p < NP; p++) begin
                if (resp[p] != 2'd0) begin
                    nchk++;
                    if (sbq[p].size() == 0) begin
                        nbad++;
                        $display("FAIL R7 port %0d unexpected response: actual resp=%0d data=%h expected none",
                                 p, resp[p], dout[p]);
                    end else begin
                        exp_t e;
                        e = sbq[p].pop_front();
                        if (resp[p] != e.r || dout[p] != e.d || cyc != e.cyc) begin
                            nbad++;
                            $display("FAIL %s port %0d: actual resp=%0d data=%h cycle=%0d expected resp=%0d data=%h cycle=%0d",
                                     e.tag, p, resp[p], dout[p], cyc, e.r, e.d, e.cyc);
                        end
                    end
                end
            end
        end
    end

    task automatic send(input int p, input logic [3:0] code, input logic [31:0] a,
                        input logic [31:0] b, input int lat, input logic [1:0] r,
                        input logic [31:0] d, input string tag, input logic [3:0] op2cmd);
        exp_t e;
        @(negedge clk);
        e.cyc = cyc + lat; e.r = r; e.d = d; e.tag = tag;
        sbq[p].push_back(e);
        cmd[p] = code;
        din[p] = a;
        @(negedge clk);
        cmd[p] = op2cmd;
        din[p] = b;
        @(negedge clk);
        cmd[p] = 4'd0;
        din[p] = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nchk++;
            nbad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs quiet during reset
        nchk++;
        if (resp != '0 || dout != '0) begin
            nbad++;
            $display("FAIL R1 during reset: actual resp=%h data=%h expected 0", resp, dout);
        end
        rst = 1'b0;
        @(negedge clk);
        nchk++;
        if (resp != '0 || dout != '0) begin
            nbad++;
            $display("FAIL R1 after reset: actual resp=%h data=%h expected 0", resp, dout);
        end

        // R2: plain add, exact latency
        send(0, 4'd1, 32'd5, 32'd7, 3, 2'd1, 32'd12, "R2", 4'd0);
        // R4: carry-out and the largest legal sum
        send(1, 4'd1, 32'hFFFF_FFFF, 32'd1, 3, 2'd2, 32'd0, "R4", 4'd0);
        send(1, 4'd1, 32'hFFFF_FFF0, 32'h0F, 3, 2'd1, 32'hFFFF_FFFF, "R4", 4'd0);
        // R3: subtract, borrow, equal operands
        send(2, 4'd2, 32'd10, 32'd3, 3, 2'd1, 32'd7, "R3", 4'd0);
        send(2, 4'd2, 32'd3, 32'd10, 3, 2'd2, 32'd0, "R3", 4'd0);
        send(2, 4'd2, 32'd5, 32'd5, 3, 2'd1, 32'd0, "R3", 4'd0);
        // R5: shifts, full range and masked amount
        send(3, 4'd5, 32'd1, 32'd31, 3, 2'd1, 32'h8000_0000, "R5", 4'd0);
        send(3, 4'd6, 32'h8000_0000, 32'd31, 3, 2'd1, 32'd1, "R5", 4'd0);
        send(3, 4'd5, 32'd3, 32'h25, 3, 2'd1, 32'h60, "R5", 4'd0);
        send(0, 4'd6, 32'hF0, 32'd4, 3, 2'd1, 32'h0F, "R5", 4'd0);
        // R6: illegal codes
        send(1, 4'd3, 32'd9, 32'd9, 2, 2'd2, 32'd0, "R6", 4'd0);
        send(1, 4'd15, 32'd9, 32'd9, 2, 2'd2, 32'd0, "R6", 4'd0);
        // R8: command lines ignored in operand-2 cycle
        send(0, 4'd1, 32'd2, 32'd3, 3, 2'd1, 32'd5, "R8", 4'd6);
        idle(2);

        // R7: no-op with data toggling, no response
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            for (int p = 0; p < NP; p++) din[p] = 32'hA5A5_0000 + k;
            nchk++;
            if (resp != '0) begin
                nbad++;
                $display("FAIL R7 noop: actual resp=%h expected 0", resp);
            end
        end
        @(negedge clk);
        din = '0;
        idle(3);

        // R9: command while waiting is refused, waiting request survives
        begin
            exp_t e;
            @(negedge clk);
            cmd[0] = 4'd1; din[0] = 32'd100;
            e.cyc = cyc + 3; e.r = 2'd2; e.d = 32'd0; e.tag = "R9 refuse";
            sbq[0].push_back(e);
            e.cyc = cyc + 4; e.r = 2'd1; e.d = 32'd123; e.tag = "R9 survive";
            sbq[0].push_back(e);
            @(negedge clk);
            cmd[0] = 4'd0; din[0] = 32'd23;
            @(negedge clk);
            cmd[0] = 4'd6; din[0] = 32'd55;
            @(negedge clk);
            cmd[0] = 4'd0; din[0] = '0;
        end
        idle(4);

        // R12: add and shift together complete together
        fork
            send(0, 4'd1, 32'd1, 32'd2, 3, 2'd1, 32'd3, "R12", 4'd0);
            send(1, 4'd5, 32'd1, 32'd4, 3, 2'd1, 32'd16, "R12", 4'd0);
        join
        idle(3);

        // R11: age beats port number; same-cycle tie goes to lower port
        fork
            send(1, 4'd1, 32'd10, 32'd1, 3, 2'd1, 32'd11, "R11", 4'd0);
            send(3, 4'd2, 32'd20, 32'd1, 4, 2'd1, 32'd19, "R11", 4'd0);
            begin
                @(negedge clk);
                send(0, 4'd1, 32'd30, 32'd1, 4, 2'd1, 32'd31, "R11", 4'd0);
            end
        join
        idle(4);

        // R10: both units contended at once, one grant each per cycle
        fork
            send(0, 4'd5, 32'd1, 32'd1, 3, 2'd1, 32'd2, "R10", 4'd0);
            send(2, 4'd6, 32'd8, 32'd1, 4, 2'd1, 32'd4, "R10", 4'd0);
            send(1, 4'd2, 32'd9, 32'd4, 3, 2'd1, 32'd5, "R10", 4'd0);
            send(3, 4'd1, 32'd9, 32'd4, 4, 2'd1, 32'd13, "R10", 4'd0);
        join
        idle(6);

        for (int p = 0; p < NP; p++) begin
            nchk++;
            if (sbq[p].size() != 0) begin
                nbad++;
                $display("FAIL R2 port %0d missing responses: actual %0d pending expected 0",
                         p, sbq[p].size());
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
        $finish;
    end

endmodule